// File: doc/BRIEF.md
# Multi-Channel DMA Channel Controller

This block keeps the programming state of a set of DMA channels and performs the bookkeeping for each burst that a device asks for. Software programs three registers per channel through a simple register port: a mode word, a remaining byte count and a start address. The mode word also holds three status flags.

A device starts a burst with a one-cycle request that carries a channel number, a direction flag and a wanted length. In that cycle the controller clears the channel's status flags. It then checks that the channel is switched on and that its programmed direction matches the request. If the check passes, it issues a command on a downstream port, takes the length as the smaller of the wanted length and the remaining count, lowers the count and flags terminal count. If the check fails, it flags a memory error and records the channel in a shared error-source register. The data movement itself and any address translation are done downstream of the command port.

Top module: `dmac_ctrl`

## Requirements
- R1: After reset, every channel register reads zero, the error-source register reads zero and `cmd_valid` is low.
- R2: Channel registers occupy offsets 0x100 upward. The channel number is (offset - 0x100) >> 5 and the register index is offset bits [4:3]. Index 1 is the mode word, 2 is the count and 3 is the address; each reads back the last value written. Index 0 reads zero and ignores writes.
- R3: A request clears mode bits 8, 9 and 10 of the requested channel. After a request exactly one of bits 8 and 9 is set, and the other mode bits are unchanged.
- R4: A request is rejected when mode bit 0 (enable) is clear, or when mode bit 1 (1 = memory to device) does not match the request direction (`req_dev_to_mem` = 1 needs bit 1 = 0). A rejected request sets mode bit 9, sets bit n of the error-source register for channel n, issues no command and leaves the count unchanged.
- R5: An accepted request produces `cmd_valid` one cycle later. The command carries the channel, the direction, the channel's address register and a length equal to min(`req_len`, count).
- R6: An accepted request sets mode bit 8 and lowers the count by the issued length.
- R7: The error-source register sits at offset 0x040 and reads as the accumulated channel bits in bits [7:0]. Writing to it clears each bit written as one and leaves the others set.
- R8: A register write that arrives in the same cycle as a request is discarded.
- R9: Reads from offsets that map to no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 12 | Read byte offset |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| req_valid | input | 1 | Burst request strobe, one cycle per request |
| req_chan | input | 3 | Requested channel |
| req_dev_to_mem | input | 1 | 1: device writes memory, 0: memory to device |
| req_len | input | 16 | Wanted burst length in bytes |
| cmd_valid | output | 1 | Downstream command strobe |
| cmd_chan | output | 3 | Command channel |
| cmd_dev_to_mem | output | 1 | Command direction |
| cmd_addr | output | 32 | Command start address |
| cmd_len | output | 16 | Command length in bytes |

## Verification
The assertions assume that the request inputs are never unknown while `req_valid` is high, and that the channel number always names an existing channel. The default of eight channels with a three-bit channel field guarantees the second point. The bench drives every input from a known value at each falling edge and only requests channels 0 to 7. It sweeps every channel through all four combinations of the enable and direction bits under both request directions. The count values are chosen so that some requests are clamped and some are not, which exercises both branches of the length rule against an arithmetic model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic [1:0] {
      IDX_RSVD  = 2'd0,
      IDX_MODE  = 2'd1,
      IDX_COUNT = 2'd2,
      IDX_ADDR  = 2'd3
   } chan_reg_e;

   localparam int unsigned BIT_EN   = 0;
   localparam int unsigned BIT_M2D  = 1;
   localparam int unsigned BIT_TC   = 8;
   localparam int unsigned BIT_MERR = 9;
   localparam int unsigned BIT_AERR = 10;

   localparam int unsigned CHAN_SPAN = 32;

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  chan_reg_e         wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_en,
   input  logic              upd_ok,
   input  logic [LEN_W-1:0]  upd_len,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] count_q,
   output logic [DATA_W-1:0] addr_q
);

   localparam logic [DATA_W-1:0] STATUS_MASK =
      (DATA_W'(1) << BIT_TC) | (DATA_W'(1) << BIT_MERR) | (DATA_W'(1) << BIT_AERR);

   if (LEN_W > DATA_W) begin : g_bad_len
      $error("dmac_chan: LEN_W must not exceed DATA_W");
   end
   if (DATA_W <= BIT_AERR) begin : g_bad_data
      $error("dmac_chan: DATA_W too narrow for status bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         count_q <= '0;
         addr_q  <= '0;
      end else if (upd_en) begin
         if (upd_ok) begin
            mode_q  <= (mode_q & ~STATUS_MASK) | (DATA_W'(1) << BIT_TC);
            count_q <= count_q - DATA_W'(upd_len);
         end else begin
            mode_q  <= (mode_q & ~STATUS_MASK) | (DATA_W'(1) << BIT_MERR);
         end
      end else if (wr_en) begin
         case (wr_idx)
            IDX_MODE:  mode_q  <= wr_data;
            IDX_COUNT: count_q <= wr_data;
            IDX_ADDR:  addr_q  <= wr_data;
            default:   ;
         endcase
      end
   end

   // R3: after a request exactly one of the status flags is up
   a_r3_one_status: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> $countones(mode_q[BIT_AERR:BIT_TC]) == 1);

   // R3: bits outside the status field survive a request
   a_r3_keep_other: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> ((mode_q ^ $past(mode_q)) & ~STATUS_MASK) == '0);

   // R4: a rejected request flags memory error and keeps the count
   a_r4_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_ok) |=> mode_q[BIT_MERR] && $stable(count_q));

   // R6: an accepted request never raises the count
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_ok) |=> mode_q[BIT_TC] && (count_q <= $past(count_q)));

endmodule

// File: rtl/dmac_check.sv
module dmac_check
   import dmac_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LEN_W  = 16
) (
   input  logic [DATA_W-1:0] mode,
   input  logic [DATA_W-1:0] count,
   input  logic              dev_to_mem,
   input  logic [LEN_W-1:0]  want_len,
   output logic              ok,
   output logic [LEN_W-1:0]  grant_len
);

   logic dir_match;

   always_comb begin
      dir_match = (mode[BIT_M2D] == !dev_to_mem);
      ok        = mode[BIT_EN] && dir_match;
      if (count < DATA_W'(want_len)) begin
         grant_len = count[LEN_W-1:0];
      end else begin
         grant_len = want_len;
      end
   end

   // R5: the granted length never exceeds either bound
   always_comb begin
      a_r5_clamp: assert ((grant_len <= want_len) && (DATA_W'(grant_len) <= count));
   end

endmodule

// File: rtl/dmac_errsrc.sv
module dmac_errsrc #(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_vec,
   input  logic              clr_en,
   input  logic [NUM_CH-1:0] clr_vec,
   output logic [NUM_CH-1:0] err_q
);

   logic [NUM_CH-1:0] clr_eff;

   always_comb clr_eff = clr_en ? clr_vec : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= (err_q & ~clr_eff) | set_vec;
   end

   // R4: a bit rises only for a channel that reported an error
   a_r4_rise_from_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_q & ~$past(err_q) & ~$past(set_vec)) == '0));

   // R7: a bit falls only when software wrote a one to it
   a_r7_fall_from_clear: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~err_q & $past(err_q) & ~($past(clr_vec) & {NUM_CH{$past(clr_en)}})) == '0));

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
   import dmac_pkg::*;
#(
   parameter int unsigned NUM_CH    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned OFF_W     = 12,
   parameter int unsigned CHAN_BASE = 12'h100,
   parameter int unsigned ERR_OFF   = 12'h040,
   parameter bit          CMD_REG   = 1'b1,
   localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [OFF_W-1:0]  reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [OFF_W-1:0]  reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              req_valid,
   input  logic [CH_W-1:0]   req_chan,
   input  logic              req_dev_to_mem,
   input  logic [LEN_W-1:0]  req_len,
   output logic              cmd_valid,
   output logic [CH_W-1:0]   cmd_chan,
   output logic              cmd_dev_to_mem,
   output logic [DATA_W-1:0] cmd_addr,
   output logic [LEN_W-1:0]  cmd_len
);

   localparam int unsigned CHAN_END = CHAN_BASE + NUM_CH * CHAN_SPAN;
   localparam int unsigned SLOT_LSB = $clog2(CHAN_SPAN);

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("dmac_ctrl: NUM_CH must be a power of two of at least 2");
   end
   if (NUM_CH > DATA_W) begin : g_bad_err_w
      $error("dmac_ctrl: error-source bits must fit in DATA_W");
   end
   if ((CHAN_BASE % CHAN_SPAN) != 0) begin : g_bad_base
      $error("dmac_ctrl: CHAN_BASE must be aligned to a channel span");
   end
   if (CHAN_END > (1 << OFF_W)) begin : g_bad_off
      $error("dmac_ctrl: OFF_W too narrow for the channel window");
   end
   if (ERR_OFF >= CHAN_BASE && ERR_OFF < CHAN_END) begin : g_bad_err_off
      $error("dmac_ctrl: ERR_OFF overlaps the channel window");
   end

   // ---------------- decode ----------------
   logic              w_hit, r_hit;
   logic [OFF_W-1:0]  w_rel, r_rel;
   logic [CH_W-1:0]   w_ch, r_ch;
   chan_reg_e         w_idx, r_idx;
   logic              wr_allowed;

   always_comb begin
      w_rel = reg_waddr - OFF_W'(CHAN_BASE);
      r_rel = reg_raddr - OFF_W'(CHAN_BASE);
      w_hit = (reg_waddr >= OFF_W'(CHAN_BASE)) && (32'(reg_waddr) < CHAN_END);
      r_hit = (reg_raddr >= OFF_W'(CHAN_BASE)) && (32'(reg_raddr) < CHAN_END);
      w_ch  = w_rel[SLOT_LSB +: CH_W];
      r_ch  = r_rel[SLOT_LSB +: CH_W];
      w_idx = chan_reg_e'(w_rel[4:3]);
      r_idx = chan_reg_e'(r_rel[4:3]);
      wr_allowed = reg_wen && !req_valid;
   end

   // ---------------- channels ----------------
   logic [DATA_W-1:0] mode_a  [NUM_CH];
   logic [DATA_W-1:0] count_a [NUM_CH];
   logic [DATA_W-1:0] addr_a  [NUM_CH];
   logic              chk_ok;
   logic [LEN_W-1:0]  chk_len;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      logic ch_wr, ch_upd;
      always_comb begin
         ch_wr  = wr_allowed && w_hit && (w_ch == CH_W'(i));
         ch_upd = req_valid && (req_chan == CH_W'(i));
      end
      dmac_chan #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (ch_wr),
         .wr_idx  (w_idx),
         .wr_data (reg_wdata),
         .upd_en  (ch_upd),
         .upd_ok  (chk_ok),
         .upd_len (chk_len),
         .mode_q  (mode_a[i]),
         .count_q (count_a[i]),
         .addr_q  (addr_a[i])
      );
   end

   // ---------------- request check ----------------
   logic [DATA_W-1:0] sel_mode, sel_count, sel_addr;

   always_comb begin
      sel_mode  = mode_a[req_chan];
      sel_count = count_a[req_chan];
      sel_addr  = addr_a[req_chan];
   end

   dmac_check #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_check (
      .mode       (sel_mode),
      .count      (sel_count),
      .dev_to_mem (req_dev_to_mem),
      .want_len   (req_len),
      .ok         (chk_ok),
      .grant_len  (chk_len)
   );

   // ---------------- error source ----------------
   logic [NUM_CH-1:0] err_set, err_q;
   logic              err_clr_en;

   always_comb begin
      err_set    = (req_valid && !chk_ok) ? (NUM_CH'(1) << req_chan) : '0;
      err_clr_en = wr_allowed && (reg_waddr == OFF_W'(ERR_OFF));
   end

   dmac_errsrc #(.NUM_CH(NUM_CH)) u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (err_set),
      .clr_en  (err_clr_en),
      .clr_vec (reg_wdata[NUM_CH-1:0]),
      .err_q   (err_q)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (reg_raddr == OFF_W'(ERR_OFF)) begin
         reg_rdata = DATA_W'(err_q);
      end else if (r_hit) begin
         case (r_idx)
            IDX_MODE:  reg_rdata = mode_a[r_ch];
            IDX_COUNT: reg_rdata = count_a[r_ch];
            IDX_ADDR:  reg_rdata = addr_a[r_ch];
            default:   reg_rdata = '0;
         endcase
      end
   end

   // ---------------- command port ----------------
   if (CMD_REG) begin : g_cmd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmd_valid      <= 1'b0;
            cmd_chan       <= '0;
            cmd_dev_to_mem <= 1'b0;
            cmd_addr       <= '0;
            cmd_len        <= '0;
         end else begin
            cmd_valid <= req_valid && chk_ok;
            if (req_valid && chk_ok) begin
               cmd_chan       <= req_chan;
               cmd_dev_to_mem <= req_dev_to_mem;
               cmd_addr       <= sel_addr;
               cmd_len        <= chk_len;
            end
         end
      end

      // R5: an issued command follows a request one cycle earlier
      a_r5_cmd_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_valid |-> $past(req_valid) && (cmd_chan == $past(req_chan)));

      // R5: issued length is bounded by the wanted length and old count
      a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_valid |-> (cmd_len <= $past(req_len)) &&
                       (DATA_W'(cmd_len) <= $past(sel_count)));

      // R4: a rejected request never turns into a command
      a_r4_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !sel_mode[BIT_EN]) |=> !cmd_valid);
   end else begin : g_cmd_comb
      always_comb begin
         cmd_valid      = req_valid && chk_ok;
         cmd_chan       = req_chan;
         cmd_dev_to_mem = req_dev_to_mem;
         cmd_addr       = sel_addr;
         cmd_len        = chk_len;
      end
   end

   // R1: the command port is quiet without a request
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (CMD_REG ? !cmd_valid : 1'b1));

endmodule

// File: tb/dmac_ctrl_tb_top.sv
module dmac_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [11:0] reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [11:0] reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [2:0]  req_chan = '0;
   logic        req_dev_to_mem = 1'b0;
   logic [15:0] req_len = '0;
   logic        cmd_valid;
   logic [2:0]  cmd_chan;
   logic        cmd_dev_to_mem;
   logic [31:0] cmd_addr;
   logic [15:0] cmd_len;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   dmac_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wen(reg_wen), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_chan(req_chan),
      .req_dev_to_mem(req_dev_to_mem), .req_len(req_len),
      .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
      .cmd_dev_to_mem(cmd_dev_to_mem), .cmd_addr(cmd_addr), .cmd_len(cmd_len)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] off(input int ch, input int idx);
      return 12'(32'h100 + ch * 32 + idx * 8);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_raddr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic request(input int ch, input logic d2m, input int len);
      @(negedge clk);
      req_valid = 1'b1; req_chan = 3'(ch); req_dev_to_mem = d2m; req_len = 16'(len);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp_err;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
      for (int c = 0; c < 8; c++) begin
         for (int i = 1; i < 4; i++) begin
            rd(off(c, i), v);
            chk("R1 channel reg", v, 32'd0);
         end
      end
      rd(12'h040, v);
      chk("R1 error source", v, 32'd0);

      // R2: register decode and readback, index 0 reserved
      for (int c = 0; c < 8; c++) begin
         wr(off(c, 0), 32'hDEAD0000 + 32'(c));
         wr(off(c, 1), 32'h0001_0010 + 32'(c));
         wr(off(c, 2), 32'h0000_1000 + 32'(c));
         wr(off(c, 3), 32'hA000_0000 + 32'(c) * 32'h100);
      end
      for (int c = 0; c < 8; c++) begin
         rd(off(c, 0), v);  chk("R2 index0", v, 32'd0);
         rd(off(c, 1), v);  chk("R2 mode", v, 32'h0001_0010 + 32'(c));
         rd(off(c, 2), v);  chk("R2 count", v, 32'h0000_1000 + 32'(c));
         rd(off(c, 3), v);  chk("R2 addr", v, 32'hA000_0000 + 32'(c) * 32'h100);
      end

      // R9: unmapped offsets
      rd(12'h000, v); chk("R9 unmapped low", v, 32'd0);
      rd(12'h200, v); chk("R9 unmapped past window", v, 32'd0);
      rd(12'hFFC, v); chk("R9 unmapped top", v, 32'd0);

      // R3..R6: sweep channels x mode(en,dir) x request direction
      exp_err = '0;
      for (int c = 0; c < 8; c++) begin
         for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
               logic [31:0] mode_w, cnt_w, addr_w, exp_mode, exp_cnt, grant;
               int len;
               logic ok;
               mode_w = 32'h0000_0730 | 32'(m);   // status bits preset
               cnt_w  = 32'(c * 9 + m * 4 + d * 3 + 5);
               addr_w = 32'h4000_0000 + 32'(c << 12) + 32'(m * 16 + d);
               len    = (m + d) * 7 + c;
               wr(off(c, 1), mode_w);
               wr(off(c, 2), cnt_w);
               wr(off(c, 3), addr_w);
               ok = (m[0] == 1'b1) && (m[1] == ~d[0]);
               grant = (32'(len) < cnt_w) ? 32'(len) : cnt_w;
               request(c, d[0], len);
               if (ok) begin
                  chk("R5 cmd_valid", 32'(cmd_valid), 32'd1);
                  chk("R5 cmd_chan", 32'(cmd_chan), 32'(c));
                  chk("R5 cmd_dir", 32'(cmd_dev_to_mem), 32'(d));
                  chk("R5 cmd_addr", cmd_addr, addr_w);
                  chk("R5 cmd_len", 32'(cmd_len), grant);
                  exp_mode = (mode_w & ~32'h700) | 32'h100;
                  exp_cnt  = cnt_w - grant;
               end else begin
                  chk("R4 no cmd", 32'(cmd_valid), 32'd0);
                  exp_mode = (mode_w & ~32'h700) | 32'h200;
                  exp_cnt  = cnt_w;
                  exp_err  = exp_err | (32'd1 << c);
               end
               rd(off(c, 1), v); chk(ok ? "R6 mode" : "R4 mode", v, exp_mode);
               rd(off(c, 1), v); chk("R3 status cleared", v & 32'h400, 32'd0);
               rd(off(c, 2), v); chk(ok ? "R6 count" : "R4 count", v, exp_cnt);
               rd(12'h040, v);  chk("R4 error source", v, exp_err);
            end
         end
      end

      // R7: write-one-to-clear on the error source
      rd(12'h040, v); chk("R7 all set", v, 32'h0000_00FF);
      wr(12'h040, 32'h0000_0005);
      rd(12'h040, v); chk("R7 partial clear", v, 32'h0000_00FA);
      wr(12'h040, 32'h0000_0000);
      rd(12'h040, v); chk("R7 zero write", v, 32'h0000_00FA);
      wr(12'h040, 32'hFFFF_FFFF);
      rd(12'h040, v); chk("R7 full clear", v, 32'd0);

      // R8: write during a request is dropped
      wr(off(5, 3), 32'h1111_2222);
      wr(off(0, 1), 32'h0000_0001);   // enabled, device-to-memory
      wr(off(0, 2), 32'h0000_0040);
      @(negedge clk);
      req_valid = 1'b1; req_chan = 3'd0; req_dev_to_mem = 1'b1; req_len = 16'd16;
      reg_wen = 1'b1; reg_waddr = off(5, 3); reg_wdata = 32'h9999_8888;
      @(negedge clk);
      req_valid = 1'b0; reg_wen = 1'b0;
      chk("R8 cmd still issued", 32'(cmd_valid), 32'd1);
      rd(off(5, 3), v); chk("R8 write dropped", v, 32'h1111_2222);
      rd(off(0, 2), v); chk("R6 count after R8", v, 32'h0000_0030);

      // R6: zero count gives a zero-length command and stays at zero
      wr(off(1, 1), 32'h0000_0003);   // enabled, memory-to-device
      wr(off(1, 2), 32'h0000_0000);
      wr(off(1, 3), 32'h0000_ABC0);
      request(1, 1'b0, 100);
      chk("R5 zero len valid", 32'(cmd_valid), 32'd1);
      chk("R5 zero len", 32'(cmd_len), 32'd0);
      rd(off(1, 2), v); chk("R6 zero count", v, 32'd0);
      @(negedge clk);
      chk("R1 cmd idle", 32'(cmd_valid), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule